// File: doc/BRIEF.md
# Endian-Selectable Bus-Width Read Unpacker

This block sits between a FIFO storage read port and a narrow-capable output port. Storage always supplies full long words made of equal-width lanes (by default four 9-bit lanes, 36 bits in all). The output port can be set up to take each long word whole, as two half words, or one lane at a time. In the two narrow modes the unpacker keeps the fetched long word in a holding register and returns one part on every read strobe. The parts come out in most-significant-first or least-significant-first order.

The size and ordering are set by three static configuration pins. These are captured while reset is held, and the captured values stay in force until the next reset. A new long word is taken from storage, through a valid/ready handshake, only after the last part of the current one has been read. The port reports empty while nothing is held. Each accepted read loads the selected part into a registered output, right-aligned, with the unused upper bits driven to zero.

Top module: `lane_unpacker`

## Requirements
- R1: While and right after reset, `out_empty` is 1, `in_ready` is 1 and `out_data` is all zeros.
- R2: With `cfg_narrow`=0 (long mode), every accepted read places the whole held long word on `out_data`. Each word is one read.
- R3: With `cfg_narrow`=1 and `cfg_byte`=0 (half mode), a word gives two reads on `out_data[17:0]`. With `cfg_msb_first`=1, the first read returns bits 35:18 and the second returns bits 17:0. With `cfg_msb_first`=0 the order is reversed.
- R4: With `cfg_narrow`=1 and `cfg_byte`=1 (lane mode), a word gives four reads on `out_data[8:0]`, where lane k is bits 9k+8:9k. With `cfg_msb_first`=1 the lanes come out in the order 3,2,1,0. With `cfg_msb_first`=0 they come out in the order 0,1,2,3.
- R5: In half and lane modes, every `out_data` bit above the part width is 0.
- R6: The configuration used is the one present on the pins at the last clock edge with `rst_n` low. Pin changes after reset release have no effect until the next reset.
- R7: In long mode, `cfg_msb_first` has no effect on the data or the read count.
- R8: `in_ready` is 1 exactly when no long word is held. A word is fetched only after all of its parts (1, 2 or 4) have been read.
- R9: `out_empty` is 1 exactly when no long word is held. A read strobe while empty leaves `out_data` unchanged and fetches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_narrow | input | 1 | 0 selects long mode, 1 selects a narrow mode |
| cfg_byte | input | 1 | In narrow mode: 0 selects half mode, 1 selects lane mode |
| cfg_msb_first | input | 1 | 1 sends the most significant part first |
| in_valid | input | 1 | Storage has a long word on `in_data` |
| in_ready | output | 1 | Unpacker takes the long word at this edge |
| in_data | input | 36 | Long word from storage |
| rd_en | input | 1 | Read strobe from the output port |
| out_data | output | 36 | Registered output part, right-aligned |
| out_empty | output | 1 | No long word or remaining part is held |

## Verification
The bench builds the block with its default parameters: four 9-bit lanes, which give 18-bit halves and a 36-bit long word. This size exercises every mode and both orders on the real lane boundaries. Each mode is run with distinct lane values, so that any swap of parts or lanes shows up. Read strobes are stalled in a repeating pattern, which puts idle reads, empty reads and back-to-back word fetches within reach. One run changes the configuration pins after reset release, to show that the captured values are the ones kept in force.

// File: rtl/lu_pkg.sv
package lu_pkg;
   typedef enum logic [1:0] {
      MODE_FULL = 2'd0,
      MODE_HALF = 2'd1,
      MODE_LANE = 2'd2
   } part_mode_t;

   function automatic int unsigned parts_per_word(part_mode_t m, int unsigned lanes);
      case (m)
         MODE_HALF: return 2;
         MODE_LANE: return lanes;
         default:   return 1;
      endcase
   endfunction
endpackage

// File: rtl/lu_cfg_latch.sv
module lu_cfg_latch
   import lu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_narrow,
   input  logic       cfg_byte,
   input  logic       cfg_msb_first,
   output part_mode_t mode_q,
   output logic       msb_q
);
   part_mode_t mode_d;

   always_comb begin
      if (!cfg_narrow)   mode_d = MODE_FULL;
      else if (cfg_byte) mode_d = MODE_LANE;
      else               mode_d = MODE_HALF;
   end

   // Tracks the pins while reset is held, then freezes.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= mode_d;
         msb_q  <= cfg_msb_first;
      end
   end
endmodule

// File: rtl/lu_hold_ctrl.sv
module lu_hold_ctrl
   import lu_pkg::*;
#(
   parameter int unsigned DW    = 36,
   parameter int unsigned LANES = 4,
   localparam int unsigned PW   = $clog2(LANES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  part_mode_t    mode,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          rd_en,
   output logic          in_ready,
   output logic          held,
   output logic [DW-1:0] word_q,
   output logic [PW-1:0] idx_q
);
   logic [PW-1:0] last_idx;

   always_comb begin
      case (mode)
         MODE_HALF: last_idx = PW'(1);
         MODE_LANE: last_idx = PW'(LANES - 1);
         default:   last_idx = '0;
      endcase
   end

   assign in_ready = !held;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held   <= 1'b0;
         word_q <= '0;
         idx_q  <= '0;
      end else if (!held) begin
         if (in_valid) begin
            held   <= 1'b1;
            word_q <= in_data;
            idx_q  <= '0;
         end
      end else if (rd_en) begin
         if (idx_q == last_idx) begin
            held  <= 1'b0;
            idx_q <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lu_part_mux.sv
module lu_part_mux
   import lu_pkg::*;
#(
   parameter int unsigned LANE_W = 9,
   parameter int unsigned LANES  = 4,
   localparam int unsigned DW    = LANE_W * LANES,
   localparam int unsigned HW    = DW / 2,
   localparam int unsigned PW    = $clog2(LANES)
) (
   input  part_mode_t    mode,
   input  logic          msb_first,
   input  logic [DW-1:0] word,
   input  logic [PW-1:0] idx,
   output logic [DW-1:0] part
);
   logic [LANE_W-1:0] lane_a [LANES];
   logic [HW-1:0]     half_a [2];
   logic [PW-1:0]     lane_sel;
   logic              half_sel;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_a[g] = word[g*LANE_W +: LANE_W];
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign half_a[h] = word[h*HW +: HW];
   end

   assign lane_sel = msb_first ? (PW'(LANES - 1) - idx) : idx;
   assign half_sel = (idx != '0) ^ msb_first;

   always_comb begin
      part = '0;
      case (mode)
         MODE_HALF: part[HW-1:0]     = half_a[half_sel];
         MODE_LANE: part[LANE_W-1:0] = lane_a[lane_sel];
         default:   part             = word;
      endcase
   end
endmodule

// File: rtl/lane_unpacker.sv
module lane_unpacker
   import lu_pkg::*;
#(
   parameter int unsigned LANE_W = 9,
   parameter int unsigned LANES  = 4,
   localparam int unsigned DW    = LANE_W * LANES,
   localparam int unsigned PW    = $clog2(LANES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_narrow,
   input  logic          cfg_byte,
   input  logic          cfg_msb_first,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   input  logic          rd_en,
   output logic [DW-1:0] out_data,
   output logic          out_empty
);
   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("lane_unpacker: LANES must be even and at least 2");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("lane_unpacker: LANE_W must be at least 1");
   end

   part_mode_t    mode_q;
   logic          msb_q;
   logic          held;
   logic [DW-1:0] word_q;
   logic [PW-1:0] idx_q;
   logic [DW-1:0] part_d;

   lu_cfg_latch u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_narrow    (cfg_narrow),
      .cfg_byte      (cfg_byte),
      .cfg_msb_first (cfg_msb_first),
      .mode_q        (mode_q),
      .msb_q         (msb_q)
   );

   lu_hold_ctrl #(.DW(DW), .LANES(LANES)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_q),
      .in_valid (in_valid),
      .in_data  (in_data),
      .rd_en    (rd_en),
      .in_ready (in_ready),
      .held     (held),
      .word_q   (word_q),
      .idx_q    (idx_q)
   );

   lu_part_mux #(.LANE_W(LANE_W), .LANES(LANES)) u_mux (
      .mode      (mode_q),
      .msb_first (msb_q),
      .word      (word_q),
      .idx       (idx_q),
      .part      (part_d)
   );

   assign out_empty = !held;

   always_ff @(posedge clk) begin
      if (!rst_n)             out_data <= '0;
      else if (rd_en && held) out_data <= part_d;
   end
endmodule

// File: rtl/lu_check.sv
module lu_check
   import lu_pkg::*;
#(
   parameter int unsigned LANE_W = 9,
   parameter int unsigned LANES  = 4,
   localparam int unsigned DW    = LANE_W * LANES,
   localparam int unsigned HW    = DW / 2,
   localparam int unsigned CW    = $clog2(LANES) + 2
) (
   input logic          clk,
   input logic          rst_n,
   input part_mode_t    mode_q,
   input logic          in_valid,
   input logic          in_ready,
   input logic          rd_en,
   input logic          out_empty,
   input logic [DW-1:0] out_data
);
   logic [CW-1:0] rd_cnt;
   logic          seen_word;
   logic          fetch;

   assign fetch = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_cnt    <= '0;
         seen_word <= 1'b0;
      end else if (fetch) begin
         rd_cnt    <= '0;
         seen_word <= 1'b1;
      end else if (rd_en && !out_empty) begin
         rd_cnt <= rd_cnt + 1'b1;
      end
   end

   // R9: a fetched word makes the port non-empty on the next cycle
   p_fill_clears_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |=> !out_empty);

   // R9: a read while empty leaves the output register alone
   p_idle_read_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && out_empty) |=> $stable(out_data));

   // R8: the next word is taken only after every part was read
   p_parts_per_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch && seen_word) |-> (32'(rd_cnt) == parts_per_word(mode_q, LANES)));

   // R5: upper bits stay zero in half mode
   p_half_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_HALF) |-> (out_data[DW-1:HW] == '0));

   // R5: upper bits stay zero in lane mode
   p_lane_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_LANE) |-> (out_data[DW-1:LANE_W] == '0));
endmodule

bind lane_unpacker lu_check #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_q    (mode_q),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .rd_en     (rd_en),
   .out_empty (out_empty),
   .out_data  (out_data)
);

// File: tb/sim_lane_unpacker.sv
`timescale 1ns/1ps
module sim_lane_unpacker;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_narrow = 1'b0, cfg_byte = 1'b0, cfg_msb_first = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_data = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] out_data;
   logic          out_empty;

   int n_cmp = 0, n_bad = 0;
   bit lt_narrow, lt_byte, lt_msb;
   logic [DW-1:0] src_q [$];
   logic [DW-1:0] exp_q [$];
   string         tag_q [$];

   always #5 clk = ~clk;

   lane_unpacker u0 (
      .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_byte(cfg_byte),
      .cfg_msb_first(cfg_msb_first), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .rd_en(rd_en), .out_data(out_data), .out_empty(out_empty)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit nar, input bit byt, input bit msb);
      @(negedge clk);
      rst_n = 1'b0; rd_en = 1'b0; in_valid = 1'b0;
      cfg_narrow = nar; cfg_byte = byt; cfg_msb_first = msb;
      lt_narrow = nar; lt_byte = byt; lt_msb = msb;
      src_q.delete(); exp_q.delete(); tag_q.delete();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Driver: queue the word and the parts the requirements predict
   task automatic push_word(input logic [DW-1:0] w);
      src_q.push_back(w);
      if (!lt_narrow) begin
         exp_q.push_back(w); tag_q.push_back(lt_msb ? "R7 long" : "R2 long");
      end else if (!lt_byte) begin
         logic [DW-1:0] hi, lo;
         hi = {18'd0, w[35:18]}; lo = {18'd0, w[17:0]};
         exp_q.push_back(lt_msb ? hi : lo); tag_q.push_back("R3 R5 half 1st");
         exp_q.push_back(lt_msb ? lo : hi); tag_q.push_back("R3 R5 half 2nd");
      end else begin
         for (int k = 0; k < 4; k++) begin
            int ln;
            ln = lt_msb ? 3 - k : k;
            exp_q.push_back({27'd0, w[9*ln +: 9]});
            tag_q.push_back($sformatf("R4 R5 lane part %0d", k));
         end
      end
   endtask

   // Driver and monitor in one negedge loop; stall > 0 drops every stall-th read
   task automatic run_traffic(input int stall);
      bit pend = 1'b0;
      for (int cyc = 0; cyc < 4000; cyc++) begin
         @(negedge clk);
         if (pend) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            chk(out_data === e, t, out_data, e);
         end
         if (in_ready !== out_empty) chk(1'b0, "R8 ready vs empty", {35'd0, in_ready}, {35'd0, out_empty});
         if (src_q.size() == 0 && exp_q.size() == 0) begin
            in_valid = 1'b0; rd_en = 1'b0;
            return;
         end
         if (src_q.size() > 0) begin
            in_valid = 1'b1; in_data = src_q[0];
            if (in_ready) void'(src_q.pop_front());
         end else begin
            in_valid = 1'b0;
         end
         rd_en = (stall == 0) ? 1'b1 : ((cyc % stall) != stall - 1);
         pend  = rd_en && !out_empty;
      end
      chk(1'b0, "R8 traffic timeout", '0, '0);
   endtask

   task automatic load_set();
      push_word(36'h8_1234_5678 ^ 36'h0);
      push_word({9'h1A3, 9'h0B5, 9'h17C, 9'h006});
      push_word(36'hF_FFFF_0000);
      push_word({9'h100, 9'h001, 9'h0FF, 9'h155});
   endtask

   initial begin
      logic [DW-1:0] keep;
      do_reset(1'b0, 1'b0, 1'b0);
      // R1: reset state
      chk(out_empty === 1'b1, "R1 out_empty", {35'd0, out_empty}, 36'd1);
      chk(in_ready === 1'b1, "R1 in_ready", {35'd0, in_ready}, 36'd1);
      chk(out_data === '0, "R1 out_data", out_data, '0);
      load_set(); run_traffic(0);                 // R2
      do_reset(1'b0, 1'b0, 1'b1);
      load_set(); run_traffic(3);                 // R7
      do_reset(1'b1, 1'b0, 1'b1);
      load_set(); run_traffic(0);                 // R3 big
      do_reset(1'b1, 1'b0, 1'b0);
      load_set(); run_traffic(4);                 // R3 little
      do_reset(1'b1, 1'b1, 1'b1);
      load_set(); run_traffic(3);                 // R4 big
      // R6: pins change after release; captured little-endian lane mode stays
      do_reset(1'b1, 1'b1, 1'b0);
      @(negedge clk);
      cfg_narrow = 1'b0; cfg_msb_first = 1'b1;
      load_set(); run_traffic(0);
      // R9: read strobe while empty changes nothing and fetches nothing
      @(negedge clk);
      keep = out_data;
      chk(out_empty === 1'b1, "R9 drained empty", {35'd0, out_empty}, 36'd1);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(out_data === keep, "R9 idle read holds data", out_data, keep);
      chk(out_empty === 1'b1, "R9 still empty", {35'd0, out_empty}, 36'd1);
      chk(in_ready === 1'b1, "R8 ready while empty", {35'd0, in_ready}, 36'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(1_000_000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual expired expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule